// File: doc/BRIEF.md
# Conversion Result Ready and Collision Tracker

This block sits between a conversion engine and a serial read-out path. Each time the engine finishes a measurement, it presents a result word with a one-cycle strobe. The block keeps the latest complete result in a holding register and raises a ready flag. The flag is offered in two forms: an active-low interrupt pin and an active-high status bit. The serial side tells the block when a read of the holding register begins and when that read finishes. A finished read clears the flag.

Two timing hazards are handled.

- **Missed result.** A result can arrive while an earlier one is still unread. The holding register takes the newer value at once. The flag drops for exactly one clock and then rises again, so an observer sees a fresh edge.
- **Collision.** A result can arrive while a read is in progress. The read is not cut short. Instead, the word being shifted out is marked invalid with a sticky flag, and the new result waits in a shadow register. It is installed when the read ends.

The sticky flag stays set until the next read begins.

Top module: `conv_ready_tracker`

## Requirements
- R1: After reset, or after a completed read, the flag is clear. A result strobe arriving while no read is active then loads the result into `data_reg` and sets `drdy` to 1 on the next cycle.
- R2: A read-complete strobe with no result arriving during that read has two effects on the next cycle: `drdy` reads 0, and `data_reg` is unchanged.
- R3: A result strobe while no read is active and `drdy` is 1 loads the new value into `data_reg` on the next cycle. On that cycle `drdy` reads 0, and it reads 1 on the cycle after.
- R4: `int_n` is always the complement of `drdy`: 0 when data is ready, 1 otherwise.
- R5: The read window runs from the cycle after a read-start strobe through the cycle of the matching read-complete strobe. A result strobe inside this window leaves `data_reg` unchanged until the read completes. It also sets `data_invalid` to 1 on the next cycle.
- R6: When a read completes and at least one result arrived inside its window (including on the completion cycle), two things happen:
  - On the next cycle, `data_reg` holds that result and `drdy` reads 0.
  - One cycle later, `drdy` reads 1.
- R7: Once set, `data_invalid` stays 1 through the end of the read and afterwards. It reads 0 on the cycle after the next read-start strobe.
- R8: When several results arrive inside one read window, the last of them is the one installed in `data_reg` when the read completes.
- R9: Synchronous active-low reset forces `drdy` = 0, `int_n` = 1, `data_invalid` = 0 and `data_reg` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe: a new conversion result is on `res_data` |
| res_data | input | DATA_W | Conversion result word |
| rd_start | input | 1 | One-cycle strobe: a read of the holding register begins |
| rd_done | input | 1 | One-cycle strobe: the read in progress has finished |
| data_reg | output | DATA_W | Holding register offered to the serial side |
| int_n | output | 1 | Active-low ready interrupt pin |
| drdy | output | 1 | Active-high ready status bit |
| data_invalid | output | 1 | Sticky flag: the current or last read was hit by a collision |

## Verification
The assertions assume the serial side keeps its strobes well ordered:

- a read-start strobe comes only while no read is active;
- a read-complete strobe comes only while a read is active;
- the two never share a cycle.

The rules on the ready flag rely on this, because it makes a direct result load and a read completion mutually exclusive. Every bench scenario issues reads through one pair of tasks, each opening and closing exactly one window. The tasks place result strobes only at chosen cycles inside or outside that window, including the completion cycle itself.

// File: rtl/conv_ready_pkg.sv
// Package: shared types for the conversion ready tracker.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package conv_ready_pkg;

    // Ready-flag state: empty, holding unread data, or forced low for one
    // clock before re-raising after a replaced or installed result.
    typedef enum logic [1:0] {
        RS_EMPTY = 2'd0,
        RS_FULL  = 2'd1,
        RS_REARM = 2'd2
    } ready_state_t;

endpackage

// File: rtl/read_tracker.sv
// Module: read_tracker
// Tracks the read window opened by rd_start and closed by rd_done, flags
// results that land inside it as collisions, and keeps the sticky invalid
// flag. Assumes rd_start only while idle, rd_done only while busy.
module read_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic res_valid,
    input  logic rd_start,
    input  logic rd_done,
    output logic busy,
    output logic collide,
    output logic invalid
);

    logic busy_q;
    logic invalid_q;

    // A result strobe inside the read window is a collision.
    assign collide = res_valid && busy_q;
    assign busy    = busy_q;
    assign invalid = invalid_q;

    // Read window register: open on start, close on done.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (rd_start) busy_q <= 1'b1;
        else if (rd_done)  busy_q <= 1'b0;
    end

    // Sticky invalid flag: set by a collision, cleared when a read begins.
    always_ff @(posedge clk) begin
        if (!rst_n)        invalid_q <= 1'b0;
        else if (rd_start) invalid_q <= 1'b0;
        else if (collide)  invalid_q <= 1'b1;
    end

    // Input protocol assumptions.
    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> !busy_q)
        else $error("read start while a read is active");
    p_done_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> busy_q)
        else $error("read complete with no read active");
    p_invalid_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> invalid_q)
        else $error("collision did not mark data invalid");
    p_invalid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !invalid_q)
        else $error("invalid flag survived a read start");
    p_invalid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_q && !rd_start |=> invalid_q)
        else $error("invalid flag dropped without a read start");

endmodule

// File: rtl/collision_buffer.sv
// Module: collision_buffer
// Shadow register for a result that collided with a read. The newest
// colliding result wins. On read completion it offers the waiting result,
// or one arriving on that same cycle, for installation.
// Assumes collide is only asserted while a read window is open.
module collision_buffer #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              collide,
    input  logic [DATA_W-1:0] res_data,
    input  logic              rd_done,
    output logic              inst_valid,
    output logic [DATA_W-1:0] inst_data
);

    logic              pend_q;
    logic [DATA_W-1:0] pend_data_q;

    // Install at read end if anything collided, preferring a same-cycle result.
    assign inst_valid = rd_done && (collide || pend_q);
    assign inst_data  = collide ? res_data : pend_data_q;

    // Pending marker: set by a collision, cleared when the read ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (rd_done) pend_q <= 1'b0;
        else if (collide) pend_q <= 1'b1;
    end

    // Shadow data: capture every colliding result, newest overwrites.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_data_q <= '0;
        else if (collide) pend_data_q <= res_data;
    end

    p_pend_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !pend_q)
        else $error("pending result left after read end");

endmodule

// File: rtl/ready_ctrl.sv
// Module: ready_ctrl
// Owns the holding register and the ready flag. Loads direct results, installs
// deferred ones, clears on read completion, and forces a one-clock low before
// re-raising when a result replaces unread data. Drives the interrupt pin from
// its own register. Assumes direct_valid and rd_done never coincide.
module ready_ctrl
    import conv_ready_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              direct_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              inst_valid,
    input  logic [DATA_W-1:0] inst_data,
    input  logic              rd_done,
    output logic [DATA_W-1:0] data_reg,
    output logic              drdy,
    output logic              int_n
);

    ready_state_t      state_q, state_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic              int_n_q;

    // Next-state and next-data selection by event priority.
    always_comb begin
        state_d = state_q;
        data_d  = data_q;
        if (inst_valid) begin
            data_d  = inst_data;
            state_d = RS_REARM;
        end else if (rd_done) begin
            state_d = RS_EMPTY;
        end else if (direct_valid) begin
            data_d  = res_data;
            state_d = (state_q == RS_FULL) ? RS_REARM : RS_FULL;
        end else if (state_q == RS_REARM) begin
            state_d = RS_FULL;
        end
    end

    // State, data and pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_EMPTY;
            data_q  <= '0;
            int_n_q <= 1'b1;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
            int_n_q <= (state_d != RS_FULL);
        end
    end

    assign data_reg = data_q;
    assign drdy     = (state_q == RS_FULL);
    assign int_n    = int_n_q;

    p_pin_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_n == !drdy)
        else $error("interrupt pin disagrees with status bit");
    p_fresh_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        direct_valid && !drdy && !rd_done |=> drdy)
        else $error("fresh result did not raise ready");
    p_done_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && !inst_valid |=> !drdy)
        else $error("completed read left ready set");
    p_missed_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        direct_valid && drdy |=> !drdy)
        else $error("replaced result did not drop ready");
    p_install_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inst_valid |=> !drdy)
        else $error("installed result did not drop ready first");
    p_rearm_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == RS_REARM && !rd_done |=> drdy)
        else $error("ready not re-raised after forced low");

endmodule

// File: rtl/conv_ready_tracker.sv
// Module: conv_ready_tracker (top)
// Latches conversion results into a holding register and reports readiness on
// an active-low pin and an active-high bit. Results colliding with a read are
// deferred to the read's end and mark that read invalid.
// Assumes well-ordered read strobes from the serial side.
module conv_ready_tracker #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              rd_start,
    input  logic              rd_done,
    output logic [DATA_W-1:0] data_reg,
    output logic              int_n,
    output logic              drdy,
    output logic              data_invalid
);

    logic              busy;
    logic              collide;
    logic              inst_valid;
    logic [DATA_W-1:0] inst_data;
    logic              direct_valid;

    // Results outside the read window go straight to the holding register.
    assign direct_valid = res_valid && !busy;

    read_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .rd_start  (rd_start),
        .rd_done   (rd_done),
        .busy      (busy),
        .collide   (collide),
        .invalid   (data_invalid)
    );

    collision_buffer #(.DATA_W(DATA_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .collide    (collide),
        .res_data   (res_data),
        .rd_done    (rd_done),
        .inst_valid (inst_valid),
        .inst_data  (inst_data)
    );

    ready_ctrl #(.DATA_W(DATA_W)) u_ready (
        .clk          (clk),
        .rst_n        (rst_n),
        .direct_valid (direct_valid),
        .res_data     (res_data),
        .inst_valid   (inst_valid),
        .inst_data    (inst_data),
        .rd_done      (rd_done),
        .data_reg     (data_reg),
        .drdy         (drdy),
        .int_n        (int_n)
    );

    p_collision_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        collide && !rd_done |=> $stable(data_reg))
        else $error("holding register changed during a read");

endmodule

// File: tb/tb_conv_ready_tracker.sv
module tb_conv_ready_tracker;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         res_valid = 1'b0;
    logic [W-1:0] res_data = '0;
    logic         rd_start = 1'b0;
    logic         rd_done = 1'b0;
    logic [W-1:0] data_reg;
    logic         int_n;
    logic         drdy;
    logic         data_invalid;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    conv_ready_tracker #(.DATA_W(W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .rd_start     (rd_start),
        .rd_done      (rd_done),
        .data_reg     (data_reg),
        .int_n        (int_n),
        .drdy         (drdy),
        .data_invalid (data_invalid)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes, then sample just after the edge.
    task automatic step(input logic rv, input logic [W-1:0] rd, input logic rs, input logic dn);
        @(negedge clk);
        res_valid = rv; res_data = rd; rd_start = rs; rd_done = dn;
        @(posedge clk);
        #1;
        res_valid = 1'b0; rd_start = 1'b0; rd_done = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 1'b0);
    endtask

    task automatic flags(input string req, input logic e_rdy, input logic e_inv);
        chk({req, " drdy"}, {23'b0, drdy}, {23'b0, e_rdy});
        chk({req, " int_n R4"}, {23'b0, int_n}, {23'b0, !e_rdy});
        chk({req, " data_invalid"}, {23'b0, data_invalid}, {23'b0, e_inv});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) idle();
        flags("R9 reset", 1'b0, 1'b0);
        chk("R9 reset data", data_reg, '0);
        rst_n = 1'b1;
        idle();
    endtask

    task automatic t_fresh();
        step(1'b1, 24'hA1B2C3, 1'b0, 1'b0);
        flags("R1 fresh", 1'b1, 1'b0);
        chk("R1 fresh data", data_reg, 24'hA1B2C3);
    endtask

    task automatic t_read_ok();
        step(1'b0, '0, 1'b1, 1'b0);
        idle(); idle();
        flags("R2 during read", 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        flags("R2 after read", 1'b0, 1'b0);
        chk("R2 data kept", data_reg, 24'hA1B2C3);
        idle();
        flags("R2 stays clear", 1'b0, 1'b0);
    endtask

    task automatic t_missed();
        step(1'b1, 24'h000111, 1'b0, 1'b0);
        flags("R1 second fresh", 1'b1, 1'b0);
        step(1'b1, 24'h000222, 1'b0, 1'b0);
        flags("R3 forced low", 1'b0, 1'b0);
        chk("R3 newer data", data_reg, 24'h000222);
        idle();
        flags("R3 re-raised", 1'b1, 1'b0);
    endtask

    task automatic t_collision();
        step(1'b0, '0, 1'b1, 1'b0);
        idle();
        step(1'b1, 24'h333333, 1'b0, 1'b0);
        chk("R5 data held", data_reg, 24'h000222);
        flags("R5 collided", 1'b1, 1'b1);
        idle();
        chk("R5 still held", data_reg, 24'h000222);
        step(1'b0, '0, 1'b0, 1'b1);
        chk("R6 installed", data_reg, 24'h333333);
        flags("R6 low after install", 1'b0, 1'b1);
        idle();
        flags("R6 raised R7 sticky", 1'b1, 1'b1);
        idle();
        flags("R7 still sticky", 1'b1, 1'b1);
        step(1'b0, '0, 1'b1, 1'b0);
        flags("R7 cleared on start", 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        flags("R2 clean read", 1'b0, 1'b0);
    endtask

    task automatic t_multi();
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b1, 24'h444444, 1'b0, 1'b0);
        step(1'b1, 24'h555555, 1'b0, 1'b0);
        chk("R8 held during read", data_reg, 24'h333333);
        flags("R8 flags mid read", 1'b0, 1'b1);
        step(1'b0, '0, 1'b0, 1'b1);
        chk("R8 last wins", data_reg, 24'h555555);
        idle();
        flags("R8 raised", 1'b1, 1'b1);
    endtask

    task automatic t_edge_done();
        step(1'b0, '0, 1'b1, 1'b0);
        flags("R7 cleared again", 1'b1, 1'b0);
        step(1'b1, 24'h666666, 1'b0, 1'b1);
        chk("R6 same-cycle install", data_reg, 24'h666666);
        flags("R6 same-cycle low", 1'b0, 1'b1);
        idle();
        flags("R6 same-cycle raised", 1'b1, 1'b1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fresh();
        t_read_ok();
        t_missed();
        t_collision();
        t_multi();
        t_edge_done();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule